// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the 32-bit control and status word of a floating-point unit. Software reads the whole word and overwrites it in one cycle. An arithmetic unit next to the block has its own side ports. It can set or clear any one of eight comparison condition codes. It can report the exception vector of a finished operation. It also reads all eight condition codes back as one packed byte.

Every reported operation replaces the cause field with its own exception vector. The sticky flag field collects the five standard exceptions until software clears them. The block raises a trap request whenever the stored cause contains an exception whose enable bit is on. An unimplemented-operation cause raises the trap request whether or not any enable is set. The rounding-mode and flush-to-zero controls are taken straight from the stored word and driven without a break to the arithmetic unit.

Exception vector encoding, used in the cause, enable and flag fields:

| Bit | Exception |
|-----|-----------|
| 0 | inexact |
| 1 | underflow |
| 2 | overflow |
| 3 | divide-by-zero |
| 4 | invalid |
| 5 | unimplemented (cause field only) |

Top module: `fp_csr`

## Requirements
- R1: While reset is held, and in the first cycle after it, the register reads as zero. This means all outputs read zero: no condition codes, no trap, round mode 0 and flush-to-zero off.
- R2: A software write stores the data in the next cycle, masked to the implemented bits 31:23, 17:0 (mask 0xFF83FFFF). Bits 22:18 always read zero. The read port always returns the stored word.
- R3: Setting or clearing condition code n changes only its bit. Code 0 is bit 23 and code n (1..7) is bit 24+n. Every other bit keeps its value.
- R4: The packed condition byte returns bit 23 as bit 0 and register bits 31:25 as bits 7:1.
- R5: A reported operation overwrites the 6-bit cause field (bits 17:12) with its exception vector, even when that vector is zero.
- R6: A reported operation ORs the low five bits of its vector into the flag field (bits 6:2). Flags stay set until software writes them to zero.
- R7: A reported operation leaves the enable field (bits 11:7), the rounding mode, flush-to-zero and all condition codes unchanged.
- R8: The trap request is high exactly when a cause bit 4..0 is set together with its enable bit, or when cause bit 5 (unimplemented) is set.
- R9: The round-mode output equals register bits 1:0. The flush-to-zero output equals register bit 24.
- R10: A software write takes priority over condition-code and exception updates in the same cycle. If set and clear of a condition code are requested together, set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write data |
| sw_rd_data | output | 32 | Stored register word |
| cc_set_en | input | 1 | Set the selected condition code |
| cc_clr_en | input | 1 | Clear the selected condition code |
| cc_idx | input | 3 | Condition code number 0..7 |
| exc_valid | input | 1 | Operation exception report strobe |
| exc_vec | input | 6 | Exception vector of the reported operation |
| cc_vec | output | 8 | Packed condition codes, code n at bit n |
| round_mode | output | 2 | Current rounding mode |
| flush_zero | output | 1 | Current flush-to-zero control |
| trap_req | output | 1 | Enabled or unimplemented exception pending in cause |

## Verification
Some behaviours are checked by the assertions on every cycle:
- masking of software writes;
- a set condition code showing up in the packed byte;
- the cause field being overwritten by each report;
- flags never dropping without a software write;
- enables holding steady across reports.

Other behaviours can only be shown by the bench's scenarios. These are:
- the scattered bit placement of each condition code;
- the trap request for enabled and unimplemented causes, but not for disabled ones;
- same-cycle priority between writes, sets, clears and reports;
- flags that survive a later clean operation.

// File: rtl/fp_csr.sv
module fp_csr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr_en,
  input  logic [31:0] sw_wr_data,
  output logic [31:0] sw_rd_data,
  input  logic        cc_set_en,
  input  logic        cc_clr_en,
  input  logic [2:0]  cc_idx,
  input  logic        exc_valid,
  input  logic [5:0]  exc_vec,
  output logic [7:0]  cc_vec,
  output logic [1:0]  round_mode,
  output logic        flush_zero,
  output logic        trap_req
);
  localparam logic [31:0] IMPL_MASK = 32'hFF83_FFFF;
  localparam int CC0_BIT   = 23;
  localparam int CCHI_BASE = 24;
  localparam int FZ_BIT    = 24;
  localparam int CAUSE_LO  = 12;
  localparam int ENA_LO    = 7;
  localparam int FLAG_LO   = 2;

  logic [31:0] csr_q, csr_nxt;
  logic [4:0]  cc_pos;
  logic [5:0]  cause;
  logic [4:0]  enables;

  assign cc_pos = (cc_idx == 3'd0) ? 5'(CC0_BIT) : 5'(CCHI_BASE) + {2'b00, cc_idx};

  always_comb begin
    csr_nxt = csr_q;
    if (cc_set_en)
      csr_nxt[cc_pos] = 1'b1;
    else if (cc_clr_en)
      csr_nxt[cc_pos] = 1'b0;
    if (exc_valid) begin
      csr_nxt[CAUSE_LO +: 6] = exc_vec;
      csr_nxt[FLAG_LO +: 5]  = csr_q[FLAG_LO +: 5] | exc_vec[4:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      csr_q <= '0;
    else if (sw_wr_en)
      csr_q <= sw_wr_data & IMPL_MASK;
    else
      csr_q <= csr_nxt;
  end

  assign cause      = csr_q[CAUSE_LO +: 6];
  assign enables    = csr_q[ENA_LO +: 5];
  assign sw_rd_data = csr_q;
  assign cc_vec     = {csr_q[31:25], csr_q[CC0_BIT]};
  assign round_mode = csr_q[1:0];
  assign flush_zero = csr_q[FZ_BIT];
  assign trap_req   = cause[5] | (|(cause[4:0] & enables));
endmodule

module fp_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_wr_en,
  input logic [31:0] sw_wr_data,
  input logic [31:0] sw_rd_data,
  input logic        cc_set_en,
  input logic [2:0]  cc_idx,
  input logic        exc_valid,
  input logic [5:0]  exc_vec,
  input logic [7:0]  cc_vec,
  input logic [1:0]  round_mode,
  input logic        flush_zero
);
  a_r2_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> sw_rd_data == ($past(sw_wr_data) & 32'hFF83_FFFF));

  a_r3_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_en && cc_set_en) |=> cc_vec[$past(cc_idx)]);

  a_r5_cause_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_en && exc_valid) |=> sw_rd_data[17:12] == $past(exc_vec));

  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en |=> (sw_rd_data[6:2] & $past(sw_rd_data[6:2])) == $past(sw_rd_data[6:2]));

  a_r7_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en |=> sw_rd_data[11:7] == $past(sw_rd_data[11:7]));

  a_r9_controls_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr_en |=> $stable(round_mode) && $stable(flush_zero));
endmodule

bind fp_csr fp_csr_chk u_chk (.*);

// File: tb/sim_fp_csr.sv
module sim_fp_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic [31:0] sw_rd_data;
  logic        cc_set_en = 1'b0;
  logic        cc_clr_en = 1'b0;
  logic [2:0]  cc_idx = '0;
  logic        exc_valid = 1'b0;
  logic [5:0]  exc_vec = '0;
  logic [7:0]  cc_vec;
  logic [1:0]  round_mode;
  logic        flush_zero;
  logic        trap_req;

  fp_csr u0 (.*);

  always #2 clk = ~clk;

  typedef struct {
    int          due;
    string       tag;
    logic [31:0] word;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] model = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pack_cc(logic [31:0] w);
    return {w[31:25], w[23]};
  endfunction

  function automatic logic trap_of(logic [31:0] w);
    return w[17] | (|(w[16:12] & w[11:7]));
  endfunction

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      logic [31:0] w;
      e = sb.pop_front();
      w = e.word;
      checks++;
      if (sw_rd_data !== w || cc_vec !== pack_cc(w) || trap_req !== trap_of(w) ||
          round_mode !== w[1:0] || flush_zero !== w[24]) begin
        errors++;
        $display("FAIL %s: got word=%h cc=%h trap=%b rm=%0d fz=%b, expected word=%h cc=%h trap=%b rm=%0d fz=%b",
                 e.tag, sw_rd_data, cc_vec, trap_req, round_mode, flush_zero,
                 w, pack_cc(w), trap_of(w), w[1:0], w[24]);
      end
    end
  end

  task automatic push(string tag);
    exp_t e;
    e.due = cyc + 1;
    e.tag = tag;
    e.word = model;
    sb.push_back(e);
  endtask

  task automatic op(string tag, logic wr, logic [31:0] d, logic st, logic cl,
                    logic [2:0] idx, logic ev, logic [5:0] v);
    int pos;
    @(negedge clk);
    sw_wr_en = wr; sw_wr_data = d; cc_set_en = st; cc_clr_en = cl;
    cc_idx = idx; exc_valid = ev; exc_vec = v;
    pos = (idx == 3'd0) ? 23 : 24 + int'(idx);
    if (wr) model = d & 32'hFF83_FFFF;
    else begin
      if (st) model[pos] = 1'b1;
      else if (cl) model[pos] = 1'b0;
      if (ev) begin
        model[17:12] = v;
        model[6:2] = model[6:2] | v[4:0];
      end
    end
    push(tag);
  endtask

  task automatic idle(string tag);
    op(tag, 1'b0, '0, 1'b0, 1'b0, 3'd0, 1'b0, 6'd0);
  endtask

  initial begin
    #100_000;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (sw_rd_data !== 32'h0 || trap_req !== 1'b0 || cc_vec !== 8'h0) begin
      errors++;
      $display("FAIL R1 in reset: got word=%h trap=%b, expected 0 0", sw_rd_data, trap_req);
    end
    rst_n = 1'b1;
    idle("R1 after reset");
    op("R2 write all ones masked", 1'b1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    op("R2 write pattern", 1'b1, 32'h0123_4567, 0, 0, 0, 0, 0);
    op("R2 clear", 1'b1, 32'h0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) op("R3 R4 set code", 0, '0, 1, 0, 3'(i), 0, 0);
    op("R3 R4 clear code 3", 0, '0, 0, 1, 3'd3, 0, 0);
    op("R3 R4 clear code 0", 0, '0, 0, 1, 3'd0, 0, 0);
    op("R9 write rm fz", 1'b1, 32'h0100_0002, 0, 0, 0, 0, 0);
    op("R3 set code 5 only", 0, '0, 1, 0, 3'd5, 0, 0);
    op("R5 R6 R7 R8 disabled overflow", 0, '0, 0, 0, 0, 1, 6'h04);
    op("R5 R6 R8 clean op keeps flags", 0, '0, 0, 0, 0, 1, 6'h00);
    op("R8 unimplemented traps", 0, '0, 0, 0, 0, 1, 6'h20);
    op("R8 enable overflow", 1'b1, 32'h0000_0200, 0, 0, 0, 0, 0);
    op("R8 enabled overflow traps", 0, '0, 0, 0, 0, 1, 6'h04);
    op("R8 R5 enabled not in cause", 0, '0, 0, 0, 0, 1, 6'h11);
    op("R6 R7 exc with code set", 0, '0, 1, 0, 3'd7, 1, 6'h08);
    op("R10 write beats exc and set", 1'b1, 32'h0000_0003, 1, 0, 3'd2, 1, 6'h1F);
    op("R10 set beats clear", 0, '0, 1, 1, 3'd1, 0, 0);
    op("R6 software clears flags", 1'b1, 32'h8000_0001, 0, 0, 0, 0, 0);
    idle("R9 R4 hold");
    idle("R9 R4 hold");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule